// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Start-Bit Validation

This block receives asynchronous serial characters on a single input line. The line idles high. The block samples it at sixteen times the bit rate, using a one-cycle enable pulse from an external rate generator. The input first passes through a two-flop synchronizer.

A falling edge seen while idle starts a sample counter. The line is checked again at the middle of the start bit, and if it has gone back high the event is treated as noise and dropped. After a confirmed start bit, the block samples five to eight data bits, least significant bit first, then an optional parity bit and one stop bit, each at the centre of its cell.

Each completed character is copied into a receive buffer. That transfer updates the data-ready, overrun, parity error, framing error and break flags. The host clears these flags with two read strobes: one for the buffer and one for the line status.

Top module: `uart_rx_core`

## Requirements
- R1: While `rst_n` is low, `data_ready`, `overrun_err`, `parity_err`, `framing_err` and `break_flag` are 0, and `rx_data` keeps the last character received.
- R2: After an idle-high line falls, the line is sampled again on the 8th `tick16` pulse. If it is high at that point, reception is abandoned and no character is produced.
- R3: Data bits are sampled 16 ticks apart, with the first received bit placed in bit 0. `word_len` 0/1/2/3 selects 5/6/7/8 bits, and the unused upper bits of `rx_data` read 0.
- R4: When `par_en` is 1, one parity bit follows the data. With `par_even`=1 the data plus parity must hold an even number of ones; with `par_even`=0 an odd number. A mismatch sets `parity_err`.
- R5: Each transfer into the buffer sets `data_ready`. A `rd_buf` pulse clears it.
- R6: A transfer that arrives while `data_ready` is still 1 sets `overrun_err`, and the buffer takes the new character.
- R7: A stop bit sampled low sets `framing_err`.
- R8: If the data, the parity (when enabled) and the stop bit are all sampled low, the block sets `break_flag` and `framing_err` and buffers a zero character. It then waits for the line to go high before it looks for a new start.
- R9: A `rd_status` pulse clears `overrun_err`, `parity_err`, `framing_err` and `break_flag`. A transfer in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| rxd | input | 1 | Serial input, idles high |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 for even parity, 0 for odd |
| rd_buf | input | 1 | Host read strobe for the buffer |
| rd_status | input | 1 | Host read strobe for line status |
| rx_data | output | 8 | Receive buffer |
| data_ready | output | 1 | Unread character present |
| overrun_err | output | 1 | Character lost before it was read |
| parity_err | output | 1 | Parity mismatch |
| framing_err | output | 1 | Stop bit was low |
| break_flag | output | 1 | Whole character was low |

## Verification
The bench sends a short low pulse, and expects the buffer and flags to stay unchanged. A design that never re-checks the start bit would instead shift in a garbage character.

Randomly configured frames cover every word length and both parity senses, with some parity bits corrupted on purpose. A wrong bit order, wrong upper-bit masking or an inverted parity sense shows up as a mismatched byte or flag.

Directed cases cover the following:
- Two unread characters, to check the overrun flag.
- A low stop bit with nonzero data, which must give a framing error without a break.
- A held-low line, which must give a break.
- Reset, to check that the buffer is preserved while the flags are cleared.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4,
    ST_HOLD  = 3'd5
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic line,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // Synchronizer chain: each stage resets to the idle-high level.
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= rxd;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign line = chain_q[STAGES-1];
  assign fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line,
  input  logic          fall,
  input  logic [1:0]    word_len,
  input  logic          par_en,
  input  logic          par_even,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          perr,
  output logic          ferr,
  output logic          brk
);
  localparam int CW   = $clog2(OSR);
  localparam int IW   = $clog2(DW);
  localparam int MID  = OSR / 2 - 1;
  localparam int LAST = OSR - 1;

  rx_state_e     state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [IW-1:0] idx_q, idx_n;
  logic [DW-1:0] sh_q, sh_n, data_q, data_n;
  logic          par_q, par_n, ones_q, ones_n, pbad_q, pbad_n;
  logic          done_q, done_n, perr_q, perr_n, ferr_q, ferr_n, brk_q, brk_n;
  logic [IW:0]   nbits;
  logic          at_mid, at_end;

  assign nbits  = (IW+1)'(DW - 3) + (IW+1)'(word_len);
  assign at_mid = tick && (cnt_q == CW'(MID));
  assign at_end = tick && (cnt_q == CW'(LAST));

  always_comb begin
    state_n = state_q;
    cnt_n   = tick ? cnt_q + 1'b1 : cnt_q;
    idx_n   = idx_q;
    sh_n    = sh_q;
    par_n   = par_q;
    ones_n  = ones_q;
    pbad_n  = pbad_q;
    done_n  = 1'b0;
    data_n  = data_q;
    perr_n  = perr_q;
    ferr_n  = ferr_q;
    brk_n   = brk_q;
    case (state_q)
      ST_IDLE: begin
        cnt_n = '0;
        if (fall) state_n = ST_START;
      end
      ST_START: if (at_mid) begin
        cnt_n = '0;
        if (line) begin
          state_n = ST_IDLE;
        end else begin
          state_n = ST_DATA;
          idx_n   = '0;
          par_n   = 1'b0;
          ones_n  = 1'b0;
          pbad_n  = 1'b0;
        end
      end
      ST_DATA: if (at_end) begin
        sh_n   = {line, sh_q[DW-1:1]};
        par_n  = par_q ^ line;
        ones_n = ones_q | line;
        if ({1'b0, idx_q} == nbits - 1'b1) state_n = par_en ? ST_PAR : ST_STOP;
        else                               idx_n   = idx_q + 1'b1;
      end
      ST_PAR: if (at_end) begin
        pbad_n  = par_q ^ line ^ ~par_even;
        ones_n  = ones_q | line;
        state_n = ST_STOP;
      end
      ST_STOP: if (at_end) begin
        done_n  = 1'b1;
        data_n  = sh_q >> (DW - int'(nbits));
        perr_n  = par_en & pbad_q;
        ferr_n  = ~line;
        brk_n   = ~line & ~ones_q;
        state_n = (~line & ~ones_q) ? ST_HOLD : ST_IDLE;
      end
      ST_HOLD: begin
        cnt_n = '0;
        if (line) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      ones_q  <= 1'b0;
      pbad_q  <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_n;
      sh_q    <= sh_n;
      par_q   <= par_n;
      ones_q  <= ones_n;
      pbad_q  <= pbad_n;
      done_q  <= done_n;
      data_q  <= data_n;
      perr_q  <= perr_n;
      ferr_q  <= ferr_n;
      brk_q   <= brk_n;
    end
  end

  assign done = done_q;
  assign data = data_q;
  assign perr = perr_q;
  assign ferr = ferr_q;
  assign brk  = brk_q;

  // R2: a high line at the start-bit centre returns the receiver to idle.
  assert_glitch_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && at_mid && line) |=> (state_q == ST_IDLE));
  // R8: after a break the receiver stays parked while the line is low.
  assert_break_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !line) |=> (state_q == ST_HOLD));
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [DW-1:0] data,
  input  logic          perr,
  input  logic          ferr,
  input  logic          brk,
  input  logic          rd_buf,
  input  logic          rd_status,
  output logic [DW-1:0] rx_data,
  output logic          data_ready,
  output logic          overrun_err,
  output logic          parity_err,
  output logic          framing_err,
  output logic          break_flag
);
  logic [DW-1:0] buf_q;
  logic          dr_q, dr_n, oe_q, oe_n, pe_q, pe_n, fe_q, fe_n, bi_q, bi_n;

  // The buffer register has no reset, so its contents survive reset.
  always_ff @(posedge clk) begin
    if (done) buf_q <= data;
  end

  always_comb begin
    dr_n = dr_q & ~rd_buf;
    oe_n = oe_q & ~rd_status;
    pe_n = pe_q & ~rd_status;
    fe_n = fe_q & ~rd_status;
    bi_n = bi_q & ~rd_status;
    if (done) begin
      dr_n = 1'b1;
      if (dr_q && !rd_buf) oe_n = 1'b1;
      if (perr) pe_n = 1'b1;
      if (ferr) fe_n = 1'b1;
      if (brk)  bi_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q <= 1'b0;
      oe_q <= 1'b0;
      pe_q <= 1'b0;
      fe_q <= 1'b0;
      bi_q <= 1'b0;
    end else begin
      dr_q <= dr_n;
      oe_q <= oe_n;
      pe_q <= pe_n;
      fe_q <= fe_n;
      bi_q <= bi_n;
    end
  end

  assign rx_data     = buf_q;
  assign data_ready  = dr_q;
  assign overrun_err = oe_q;
  assign parity_err  = pe_q;
  assign framing_err = fe_q;
  assign break_flag  = bi_q;

  assert_ready_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> data_ready);
  assert_ready_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_buf && !done) |=> !data_ready);
  assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && data_ready && !rd_buf) |=> overrun_err);
  assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !done) |=> !(overrun_err || parity_err || framing_err || break_flag));
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int DW      = 8,
  parameter int OSR     = 16,
  parameter int SYNC_FF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rxd,
  input  logic [1:0]    word_len,
  input  logic          par_en,
  input  logic          par_even,
  input  logic          rd_buf,
  input  logic          rd_status,
  output logic [DW-1:0] rx_data,
  output logic          data_ready,
  output logic          overrun_err,
  output logic          parity_err,
  output logic          framing_err,
  output logic          break_flag
);
  logic          line, fall, done, perr, ferr, brk;
  logic [DW-1:0] data;

  uart_rx_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .line(line), .fall(fall)
  );

  uart_rx_frame #(.DW(DW), .OSR(OSR)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line), .fall(fall),
    .word_len(word_len), .par_en(par_en), .par_even(par_even),
    .done(done), .data(data), .perr(perr), .ferr(ferr), .brk(brk)
  );

  uart_rx_status #(.DW(DW)) u_status (
    .clk(clk), .rst_n(rst_n), .done(done), .data(data), .perr(perr),
    .ferr(ferr), .brk(brk), .rd_buf(rd_buf), .rd_status(rd_status),
    .rx_data(rx_data), .data_ready(data_ready), .overrun_err(overrun_err),
    .parity_err(parity_err), .framing_err(framing_err), .break_flag(break_flag)
  );
endmodule

// File: tb/uart_rx_core_bench.sv
module uart_rx_core_bench;
  localparam int TPER = 3;
  localparam int BIT  = 16 * TPER;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] word_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic       rd_buf = 1'b0;
  logic       rd_status = 1'b0;
  logic [7:0] rx_data;
  logic       data_ready, overrun_err, parity_err, framing_err, break_flag;

  int n_checks = 0;
  int n_fail   = 0;
  int tcnt     = 0;
  bit done_run = 0;

  uart_rx_core u_uart_rx_core (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .word_len(word_len),
    .par_en(par_en), .par_even(par_even), .rd_buf(rd_buf), .rd_status(rd_status),
    .rx_data(rx_data), .data_ready(data_ready), .overrun_err(overrun_err),
    .parity_err(parity_err), .framing_err(framing_err), .break_flag(break_flag)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tcnt   <= (tcnt == TPER - 1) ? 0 : tcnt + 1;
    tick16 <= (tcnt == TPER - 1);
  end

  function automatic logic [7:0] mask_of(input logic [1:0] wl);
    return 8'hFF >> (3 - wl);
  endfunction

  function automatic logic good_par(input logic [7:0] d, input logic even);
    return even ? ^d : ~^d;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int clocks);
    rxd = v;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic pbit, input logic stopv);
    hold(1'b0, BIT);
    for (int i = 0; i < 5 + int'(word_len); i++) hold(d[i], BIT);
    if (par_en) hold(pbit, BIT);
    hold(stopv, BIT);
    hold(1'b1, 2 * BIT);
  endtask

  task automatic pulse_rd(input logic b, input logic s);
    rd_buf = b;
    rd_status = s;
    @(negedge clk);
    rd_buf = 1'b0;
    rd_status = 1'b0;
    @(negedge clk);
  endtask

  task automatic frame_check(input logic [7:0] d, input logic pbit, input logic stopv, input string tag);
    logic [7:0] m;
    logic       pe, fe, bi;
    m  = d & mask_of(word_len);
    pe = par_en && (pbit != good_par(m, par_even));
    fe = ~stopv;
    bi = ~stopv && (m == 8'h00) && (!par_en || !pbit);
    send(d, pbit, stopv);
    check({tag, " R3 data"}, rx_data, m);
    check({tag, " R5 ready"}, data_ready, 1'b1);
    check({tag, " R4 parity"}, parity_err, pe);
    check({tag, " R7 framing"}, framing_err, fe);
    check({tag, " R8 break"}, break_flag, bi);
    pulse_rd(1'b1, 1'b1);
    check({tag, " R5 ready clear"}, data_ready, 1'b0);
    check({tag, " R9 status clear"}, {overrun_err, parity_err, framing_err, break_flag}, 4'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_run) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    check("R1 reset flags", {data_ready, overrun_err, parity_err, framing_err, break_flag}, 5'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Plain 8-bit frame, no parity
    word_len = 2'd3; par_en = 1'b0;
    frame_check(8'hA5, 1'b0, 1'b1, "dir8");

    // R2: short low glitch must not start a character
    hold(1'b0, 5 * TPER);
    hold(1'b1, 14 * BIT);
    check("R2 glitch ready", data_ready, 1'b0);
    check("R2 glitch data", rx_data, 8'hA5);

    // Random frames
    for (int k = 0; k < 24; k++) begin
      logic [7:0] d;
      logic       pb, st;
      word_len = 2'($urandom_range(0, 3));
      par_en   = 1'($urandom_range(0, 1));
      par_even = 1'($urandom_range(0, 1));
      d  = 8'($urandom);
      pb = good_par(d & mask_of(word_len), par_even);
      if ($urandom_range(0, 3) == 0) pb = ~pb;
      st = ($urandom_range(0, 5) != 0);
      frame_check(d, pb, st, "rand");
    end

    // R6: two characters without reading
    word_len = 2'd3; par_en = 1'b0;
    send(8'h11, 1'b0, 1'b1);
    send(8'h22, 1'b0, 1'b1);
    check("R6 overrun flag", overrun_err, 1'b1);
    check("R6 newest data", rx_data, 8'h22);
    pulse_rd(1'b1, 1'b1);
    check("R9 overrun cleared", overrun_err, 1'b0);

    // R7: low stop with nonzero data is framing, not break
    frame_check(8'h3C, 1'b0, 1'b0, "stoplow");

    // R8: line held low for a long time
    word_len = 2'd3; par_en = 1'b1; par_even = 1'b1;
    hold(1'b0, 14 * BIT);
    check("R8 break flag", break_flag, 1'b1);
    check("R8 break framing", framing_err, 1'b1);
    check("R8 break data", rx_data, 8'h00);
    hold(1'b1, 3 * BIT);
    check("R8 single char", overrun_err, 1'b0);
    pulse_rd(1'b1, 1'b1);

    // R1: reset keeps the buffer and clears the flags
    par_en = 1'b0;
    send(8'h6B, 1'b0, 1'b0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset flags", {data_ready, overrun_err, parity_err, framing_err, break_flag}, 5'b0);
    check("R1 buffer kept", rx_data, 8'h6B);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    frame_check(8'h5A, 1'b0, 1'b1, "post");

    done_run = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule